// File: doc/BRIEF.md
# Noise and Triangle Wave Generator for a 12-bit Converter Channel

This block sits in front of the output data register of one converter channel. It can add a generated offset to the value software has placed in the holding register. On each accepted trigger it advances one of two generators. The first is a 12-bit linear feedback shift register (LFSR) that produces pseudo-random noise. The second is an up/down counter that produces a triangle wave. The block then loads the output register with the holding value plus the generated value, saturated at full scale.

A 2-bit waveform selector chooses no generation, noise or triangle. A single 4-bit span code serves both generators. For noise it sets how many low LFSR bits pass through. For the triangle it sets the peak count. When triggering is switched off, the output register simply tracks the holding value one cycle later and both generators stand still. Switching the channel off returns both generators to their start state.

Top module: `dac_wave_synth`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dout` becomes 0, the LFSR returns to its seed 12'hACE and the triangle counter returns to 0, counting up.
- R2: With `chan_on`=1 and `trig_en`=0, `dout` equals the `base_val` sampled at the previous rising edge. `trig` has no effect, and neither generator advances.
- R3: With `chan_on`=1 and `trig_en`=1, `dout` changes only at an edge where `trig` is 1. In that case, with `wave_sel`=2'b00, it loads `base_val` unchanged.
- R4: With `wave_sel`=2'b01, each accepted trigger shifts the LFSR left by one, so that the new state is {s[10:0], s[11]^s[5]^s[3]^s[0]} (polynomial x^12+x^6+x^4+x+1). On the same edge `dout` loads `base_val` plus the new state ANDed with the span mask. The LFSR moves only on accepted triggers in noise mode.
- R5: For noise, a span code n from 0 to 10 gives the mask 2^(n+1)-1, which passes bits n down to 0. Codes 11 to 15 give the mask 12'hFFF.
- R6: With `wave_sel`=2'b10 or 2'b11, each accepted trigger steps the triangle counter by one. It counts up until it reaches the peak, then down to 0, then up again. On the same edge `dout` loads `base_val` plus the new count. The counter moves only on accepted triggers in triangle mode.
- R7: The triangle peak is 2^(n+1)-1 for span code n from 0 to 10, and 4095 for codes 11 to 15.
- R8: Whenever the sum of `base_val` and the generated value exceeds 4095, `dout` loads 4095.
- R9: While `chan_on`=0, `dout` holds its value whatever the other inputs do. The LFSR is reloaded with its seed, and the triangle counter is cleared to 0, counting up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| chan_on | input | 1 | Channel enable |
| trig_en | input | 1 | 1: outputs update on triggers; 0: output tracks the holding value |
| trig | input | 1 | Trigger strobe, one accepted trigger per high cycle |
| wave_sel | input | 2 | 00 none, 01 noise, 1x triangle |
| amp_code | input | 4 | Span code: noise unmask width or triangle peak |
| base_val | input | 12 | Holding-register value |
| dout | output | 12 | Output register value |

## Verification
The bench runs the triangle at span code 13 all the way to 4095 and back to 4094. A decoder that did not saturate codes at or above 11 would wrap the peak and fail there. It also runs a short triangle at peak 3 through both turnarounds, which catches a counter that overshoots the peak or skips 0. Holding values near full scale are added to noise and triangle values to expose an adder that wraps instead of clamping. Triggers are also pulsed while triggering is off and while the channel is off. A later noise sequence that does not start from the seed shows that a generator advanced when it should have stood still.

// File: rtl/wsynth_pkg.sv
package wsynth_pkg;

    parameter int WS_DW = 12;
    parameter int WS_CW = 4;

    typedef enum logic [1:0] {
        WV_OFF     = 2'b00,
        WV_NOISE   = 2'b01,
        WV_TRI     = 2'b10,
        WV_TRI_ALT = 2'b11
    } wave_mode_e;

    typedef struct packed {
        logic               down;
        logic [WS_DW-1:0]   cnt;
    } tri_state_t;

    function automatic logic is_triangle(input wave_mode_e m);
        return (m == WV_TRI) || (m == WV_TRI_ALT);
    endfunction

endpackage

// File: rtl/wsynth_span.sv
module wsynth_span
    import wsynth_pkg::*;
#(
    parameter int DW = WS_DW,
    parameter int CW = WS_CW
) (
    input  logic [CW-1:0] code,
    output logic [DW-1:0] span
);
    localparam int CODE_MAX = (1 << CW) - 1;

    initial begin
        if (CODE_MAX < DW - 1)
            $error("span code too narrow for data width");
    end

    // Thermometer decode: bit i is open when the code reaches i.
    // Codes past the top bit open every bit, which gives saturation.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign span[i] = (int'(code) >= i);
    end
endmodule

// File: rtl/wsynth_lfsr.sv
module wsynth_lfsr #(
    parameter int              DW   = wsynth_pkg::WS_DW,
    parameter logic [DW-1:0]   SEED = DW'(12'hACE),
    parameter logic [DW-1:0]   TAPS = DW'(12'b1000_0010_1001)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [DW-1:0] shifted,
    output logic [DW-1:0] state
);
    logic fb;

    assign fb      = ^(state & TAPS);
    assign shifted = {state[DW-2:0], fb};

    always_ff @(posedge clk) begin
        if (rst || clr)
            state <= SEED;
        else if (step)
            state <= shifted;
    end

    p_lfsr_live_r4: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    p_lfsr_still_r4: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(state));

    p_lfsr_reload_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (state == SEED));
endmodule

// File: rtl/wsynth_tri.sv
module wsynth_tri
    import wsynth_pkg::*;
#(
    parameter int DW = WS_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic [DW-1:0] peak,
    output logic [DW-1:0] cnt_nx,
    output logic [DW-1:0] cnt
);
    tri_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (!cur.down) begin
            if (cur.cnt >= peak) begin
                nxt.down = 1'b1;
                nxt.cnt  = cur.cnt - 1'b1;
            end else begin
                nxt.cnt  = cur.cnt + 1'b1;
            end
        end else begin
            if (cur.cnt == '0) begin
                nxt.down = 1'b0;
                nxt.cnt  = cur.cnt + 1'b1;
            end else begin
                nxt.cnt  = cur.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cur <= '0;
        else if (step)
            cur <= nxt;
    end

    assign cnt_nx = nxt.cnt;
    assign cnt    = cur.cnt;

    p_tri_unit_step_r6: assert property (@(posedge clk) disable iff (rst)
        (step && !clr) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));

    p_tri_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/wsynth_mix.sv
module wsynth_mix
    import wsynth_pkg::*;
#(
    parameter int DW = WS_DW
) (
    input  wave_mode_e    mode,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] noise_v,
    input  logic [DW-1:0] tri_v,
    input  logic [DW-1:0] span,
    output logic [DW-1:0] sum
);
    logic [DW-1:0] gen;
    logic [DW:0]   wide;

    always_comb begin
        if (mode == WV_NOISE)
            gen = noise_v & span;
        else if (is_triangle(mode))
            gen = tri_v;
        else
            gen = '0;
        wide = {1'b0, base} + {1'b0, gen};
        sum  = wide[DW] ? '1 : wide[DW-1:0];
    end
endmodule

// File: rtl/dac_wave_synth.sv
module dac_wave_synth
    import wsynth_pkg::*;
#(
    parameter int            DW   = WS_DW,
    parameter int            CW   = WS_CW,
    parameter logic [DW-1:0] SEED = DW'(12'hACE)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_on,
    input  logic          trig_en,
    input  logic          trig,
    input  logic [1:0]    wave_sel,
    input  logic [CW-1:0] amp_code,
    input  logic [DW-1:0] base_val,
    output logic [DW-1:0] dout
);
    wave_mode_e    mode;
    logic          fire, noise_step, tri_step, clr;
    logic [DW-1:0] span, lfsr_nx, lfsr_q, tri_nx, tri_q, mixed;

    assign mode       = wave_mode_e'(wave_sel);
    assign clr        = !chan_on;
    assign fire       = chan_on && trig_en && trig;
    assign noise_step = fire && (mode == WV_NOISE);
    assign tri_step   = fire && is_triangle(mode);

    wsynth_span #(.DW(DW), .CW(CW)) u_span (
        .code (amp_code),
        .span (span)
    );

    wsynth_lfsr #(.DW(DW), .SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .step    (noise_step),
        .shifted (lfsr_nx),
        .state   (lfsr_q)
    );

    wsynth_tri #(.DW(DW)) u_tri (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .step   (tri_step),
        .peak   (span),
        .cnt_nx (tri_nx),
        .cnt    (tri_q)
    );

    wsynth_mix #(.DW(DW)) u_mix (
        .mode    (mode),
        .base    (base_val),
        .noise_v (lfsr_nx),
        .tri_v   (tri_nx),
        .span    (span),
        .sum     (mixed)
    );

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (chan_on) begin
            if (!trig_en)
                dout <= base_val;
            else if (trig)
                dout <= mixed;
        end
    end

    p_follow_base_r2: assert property (@(posedge clk) disable iff (rst)
        (chan_on && !trig_en) |=> (dout == $past(base_val)));

    p_hold_no_trig_r3: assert property (@(posedge clk) disable iff (rst)
        (chan_on && trig_en && !trig) |=> $stable(dout));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        fire |=> (dout >= $past(base_val)));

    p_off_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !chan_on |=> $stable(dout));

    p_tri_within_r7: assert property (@(posedge clk) disable iff (rst)
        (tri_step && $stable(amp_code)) |=> (tri_q <= span || tri_q < $past(tri_q)));
endmodule

// File: tb/dac_wave_synth_test.sv
`timescale 1ns/1ps
module dac_wave_synth_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_on = 1'b0;
    logic        trig_en = 1'b0;
    logic        trig = 1'b0;
    logic [1:0]  wave_sel = 2'b00;
    logic [3:0]  amp_code = 4'd0;
    logic [11:0] base_val = 12'd0;
    logic [11:0] dout;

    int n_run = 0;
    int n_bad = 0;
    logic [11:0] m_lfsr;
    logic [11:0] m_cnt;
    bit          m_down;

    always #2.5 clk = ~clk;

    dac_wave_synth uut (
        .clk(clk), .rst(rst), .chan_on(chan_on), .trig_en(trig_en), .trig(trig),
        .wave_sel(wave_sel), .amp_code(amp_code), .base_val(base_val), .dout(dout)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: dout=%0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] span_of(input int code);
        return (code >= 11) ? 12'hFFF : 12'((1 << (code + 1)) - 1);
    endfunction

    function automatic logic [11:0] sat_add(input logic [11:0] a, input logic [11:0] b);
        int s = int'(a) + int'(b);
        return (s > 4095) ? 12'hFFF : 12'(s);
    endfunction

    function automatic logic [11:0] lfsr_next(input logic [11:0] s);
        return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
    endfunction

    task automatic tri_next(input logic [11:0] peak);
        if (!m_down) begin
            if (m_cnt >= peak) begin m_down = 1'b1; m_cnt = m_cnt - 1; end
            else m_cnt = m_cnt + 1;
        end else begin
            if (m_cnt == 0) begin m_down = 1'b0; m_cnt = m_cnt + 1; end
            else m_cnt = m_cnt - 1;
        end
    endtask

    task automatic model_clear();
        m_lfsr = 12'hACE;
        m_cnt  = 12'd0;
        m_down = 1'b0;
    endtask

    task automatic fire_once();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic cycle_off();
        @(negedge clk) chan_on = 1'b0;
        @(negedge clk) chan_on = 1'b1;
        model_clear();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset output", dout, 12'd0);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check("R1 output after reset release, channel off", dout, 12'd0);
    endtask

    task automatic t_passthrough();
        chan_on = 1'b1; trig_en = 1'b0; wave_sel = 2'b01; amp_code = 4'd15;
        base_val = 12'h123;
        @(negedge clk);
        check("R2 tracks base", dout, 12'h123);
        base_val = 12'h456;
        fire_once();
        check("R2 trigger ignored, base followed", dout, 12'h456);
        wave_sel = 2'b10;
        fire_once();
        check("R2 trigger ignored in triangle mode", dout, 12'h456);
    endtask

    task automatic t_off_mode();
        trig_en = 1'b1; wave_sel = 2'b00; base_val = 12'h200;
        repeat (3) @(negedge clk);
        check("R3 holds without trigger", dout, 12'h456);
        fire_once();
        check("R3 no-generation trigger loads base", dout, 12'h200);
    endtask

    task automatic t_noise();
        int codes[6] = '{0, 3, 7, 10, 11, 15};
        wave_sel = 2'b01; base_val = 12'h010;
        foreach (codes[k]) begin
            amp_code = 4'(codes[k]);
            for (int j = 0; j < 2; j++) begin
                fire_once();
                m_lfsr = lfsr_next(m_lfsr);
                check($sformatf("R4 R5 noise code %0d", codes[k]), dout,
                      sat_add(base_val, m_lfsr & span_of(codes[k])));
            end
        end
    endtask

    task automatic t_triangle();
        cycle_off();
        wave_sel = 2'b10; amp_code = 4'd1; base_val = 12'h100;
        for (int j = 0; j < 10; j++) begin
            if (j == 5) wave_sel = 2'b11;
            fire_once();
            tri_next(12'd3);
            check($sformatf("R6 triangle step %0d", j), dout, 12'h100 + m_cnt);
        end
    endtask

    task automatic t_tri_full();
        cycle_off();
        wave_sel = 2'b10; amp_code = 4'd13; base_val = 12'd0;
        for (int j = 1; j <= 4096; j++) begin
            fire_once();
            tri_next(12'hFFF);
            if (j == 2047 || j == 4095 || j == 4096)
                check($sformatf("R7 full-scale triangle trigger %0d", j), dout, m_cnt);
        end
    endtask

    task automatic t_saturate();
        cycle_off();
        wave_sel = 2'b10; amp_code = 4'd2; base_val = 12'd4093;
        for (int j = 0; j < 3; j++) begin
            fire_once();
            tri_next(12'd7);
            check("R8 triangle sum clamps", dout, sat_add(12'd4093, m_cnt));
        end
        wave_sel = 2'b01; amp_code = 4'd15; base_val = 12'hFFF;
        fire_once();
        m_lfsr = lfsr_next(m_lfsr);
        check("R8 noise sum clamps", dout, 12'hFFF);
    endtask

    task automatic t_disable();
        logic [11:0] held;
        wave_sel = 2'b01; amp_code = 4'd11; base_val = 12'd5;
        fire_once();
        fire_once();
        held = dout;
        @(negedge clk) chan_on = 1'b0; base_val = 12'd900;
        fire_once();
        trig_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 output held while channel off", dout, held);
        trig_en = 1'b1; chan_on = 1'b1;
        model_clear();
        fire_once();
        m_lfsr = lfsr_next(m_lfsr);
        check("R9 noise restarts from seed", dout, sat_add(12'd900, m_lfsr));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_passthrough();
        t_off_mode();
        t_noise();
        t_triangle();
        t_tri_full();
        t_saturate();
        t_disable();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule